// File: doc/BRIEF.md
# Serial Receive Character Queue with Trigger Interrupt

This block holds characters that a serial receiver has already assembled, together with four per-character error bits, until software reads them through the data register. A mode input chooses between two depths at run time. When the mode is on, the block is a 16-slot circular queue. When the mode is off, it is a single holding slot. Any change of the mode empties the queue at once.

A receive interrupt request is raised when a push brings the occupancy exactly to the trigger level. A data-register read drops the request when the occupancy before that read was exactly the trigger level. This is an exact-count match and not a threshold compare. Each read also copies the error bits of the character being read into a small status register, and a separate strobe clears that register.

The upstream receiver watches the free-slot count, so it never has to push into a full queue. A push that arrives when the queue is full is dropped.

Each entry is 12 bits wide:
- bits [7:0] hold the character;
- bit 8 is the framing error;
- bit 9 is the parity error;
- bit 10 is the break;
- bit 11 is the overrun.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the mode is single-slot. The outputs are `empty`=1, `full`=0, `rx_irq`=0, `rx_status`=0, `free_slots`=1 and `head_data`=0.
- R2: `free_slots` always equals the effective depth minus the occupancy. The effective depth is 16 with `fifo_en`=1 and 1 with `fifo_en`=0.
- R3: A push is dropped when the occupancy, after any pop in the same cycle, already equals the depth. A dropped push changes neither the occupancy nor the stored entries.
- R4: Entries leave in the order they were pushed. The read position wraps modulo the depth.
- R5: `full` is set by a push that brings the occupancy to the depth. Any read of the data register clears it.
- R6: `empty` is set by a read that leaves the occupancy at zero. Any accepted push clears it.
- R7: An accepted push that makes the occupancy equal `trig_lvl` sets `rx_irq`. Pushes that go past the trigger level do not set it again.
- R8: A read clears `rx_irq` when the occupancy after the read, plus one, equals `trig_lvl`.
- R9: In a cycle where `fifo_en` differs from the stored mode, the block adopts the new mode and flushes the queue. The occupancy and read position go to zero, `empty`=1 and `full`=0. A push or pop in that cycle is ignored, and `rx_irq` keeps its value.
- R10: A read while the queue is empty leaves the occupancy and read position unchanged. `head_data` keeps showing the stale entry at the read position.
- R11: A read loads `rx_status` with bits [11:8] of the head entry (overrun, break, parity, framing). `status_clr` zeroes `rx_status`. When both happen in the same cycle, the read wins.
- R12: With a push and a pop in the same cycle, the pop is applied first. A full queue therefore accepts the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Mode: 1 = 16-slot queue, 0 = single slot |
| trig_lvl | input | 5 | Occupancy at which the interrupt is raised |
| push | input | 1 | Store `push_data` |
| push_data | input | 12 | Character plus error bits |
| pop | input | 1 | Data-register read strobe |
| status_clr | input | 1 | Clear the receive status register |
| head_data | output | 12 | Entry at the read position |
| free_slots | output | 5 | Depth minus occupancy |
| full | output | 1 | Queue full flag |
| empty | output | 1 | Queue empty flag |
| rx_irq | output | 1 | Receive interrupt request |
| rx_status | output | 4 | Error bits of the last character read |

## Verification
The hardest state to reach from the ports is a mode change that lands while the interrupt is pending and the queue holds data. In that state the flush must empty the queue but leave the request alone. The stimulus reaches it on purpose: it fills the queue past a non-unit trigger, then flips the mode with a push on the same cycle. Random runs add rare mode flips on top of dense push/pop traffic, so flushes also land at wrapped read positions and with simultaneous push and pop.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    parameter int unsigned RXQ_DEPTH = 16;
    parameter int unsigned CHAR_W    = 8;
    parameter int unsigned ERR_W     = 4;
    parameter int unsigned ENTRY_W   = CHAR_W + ERR_W;
    parameter int unsigned CNT_W     = $clog2(RXQ_DEPTH + 1);
    parameter int unsigned PTR_W     = $clog2(RXQ_DEPTH);

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [PTR_W-1:0]   ptr_t;
    typedef logic [ERR_W-1:0]   err_t;

    typedef struct packed {
        logic mode;
        ptr_t rd_ptr;
        cnt_t count;
        logic full;
        logic empty;
        logic irq;
        err_t status;
    } rxq_state_t;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
    import uart_rxq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  ptr_t   wr_idx,
    input  entry_t wr_data,
    input  ptr_t   rd_idx,
    output entry_t rd_data
);
    entry_t slot_q [RXQ_DEPTH];

    for (genvar g = 0; g < RXQ_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == ptr_t'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_in,
    input  cnt_t trig_lvl,
    input  logic push,
    input  logic pop,
    input  logic status_clr,
    input  err_t head_err,
    output logic wr_en,
    output ptr_t wr_idx,
    output ptr_t rd_idx,
    output cnt_t depth,
    output cnt_t count,
    output logic full,
    output logic empty,
    output logic irq,
    output err_t status,
    output logic mode_q
);
    localparam cnt_t DEPTH_ON  = cnt_t'(RXQ_DEPTH);
    localparam cnt_t DEPTH_OFF = cnt_t'(1);

    rxq_state_t st_q, st_d;
    cnt_t       cnt_pop;
    cnt_t       cnt_push;
    ptr_t       ptr_pop;
    ptr_t       mask;
    logic       flush;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        depth    = st_q.mode ? DEPTH_ON : DEPTH_OFF;
        mask     = ptr_t'(depth - cnt_t'(1));
        flush    = (mode_in != st_q.mode);
        cnt_pop  = st_q.count;
        ptr_pop  = st_q.rd_ptr;
        cnt_push = st_q.count;
        wr_idx   = '0;

        if (status_clr) begin
            st_d.status = '0;
        end

        if (flush) begin
            st_d.mode   = mode_in;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
            st_d.full   = 1'b0;
            st_d.empty  = 1'b1;
        end else begin
            if (pop) begin
                st_d.status = head_err;
                st_d.full   = 1'b0;
                if (st_q.count != '0) begin
                    cnt_pop = st_q.count - cnt_t'(1);
                    ptr_pop = (st_q.rd_ptr + ptr_t'(1)) & mask;
                end
                if (cnt_pop == '0) begin
                    st_d.empty = 1'b1;
                end
                if ((cnt_pop + cnt_t'(1)) == trig_lvl) begin
                    st_d.irq = 1'b0;
                end
            end
            cnt_push = cnt_pop;
            if (push && (cnt_pop < depth)) begin
                wr_en      = 1'b1;
                wr_idx     = (ptr_pop + ptr_t'(cnt_pop)) & mask;
                cnt_push   = cnt_pop + cnt_t'(1);
                st_d.empty = 1'b0;
                if (cnt_push == depth) begin
                    st_d.full = 1'b1;
                end
                if (cnt_push == trig_lvl) begin
                    st_d.irq = 1'b1;
                end
            end
            st_d.rd_ptr = ptr_pop;
            st_d.count  = cnt_push;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.empty  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx = st_q.rd_ptr;
    assign count  = st_q.count;
    assign full   = st_q.full;
    assign empty  = st_q.empty;
    assign irq    = st_q.irq;
    assign status = st_q.status;
    assign mode_q = st_q.mode;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic [CNT_W-1:0]   trig_lvl,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    input  logic               status_clr,
    output logic [ENTRY_W-1:0] head_data,
    output logic [CNT_W-1:0]   free_slots,
    output logic               full,
    output logic               empty,
    output logic               rx_irq,
    output logic [ERR_W-1:0]   rx_status
);
    logic   wr_en;
    ptr_t   wr_idx;
    ptr_t   rd_idx;
    cnt_t   depth;
    cnt_t   count;
    logic   mode_q;
    entry_t rd_data;

    uart_rxq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_in    (fifo_en),
        .trig_lvl   (trig_lvl),
        .push       (push),
        .pop        (pop),
        .status_clr (status_clr),
        .head_err   (rd_data[ENTRY_W-1 -: ERR_W]),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .depth      (depth),
        .count      (count),
        .full       (full),
        .empty      (empty),
        .irq        (rx_irq),
        .status     (rx_status),
        .mode_q     (mode_q)
    );

    uart_rxq_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign head_data  = rd_data;
    assign free_slots = depth - count;
endmodule

// File: rtl/uart_rx_queue_checker.sv
module uart_rx_queue_checker
    import uart_rxq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fifo_en,
    input logic               mode_q,
    input logic               push,
    input logic               pop,
    input logic               status_clr,
    input logic [CNT_W-1:0]   depth,
    input logic               full,
    input logic               empty,
    input logic [CNT_W-1:0]   free_slots,
    input logic [ENTRY_W-1:0] head_data,
    input logic               rx_irq,
    input logic [ERR_W-1:0]   rx_status
);
    p_full_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full == (free_slots == '0));

    p_empty_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (free_slots == depth));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots <= depth);

    p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && (fifo_en == mode_q)) |=> (full && $stable(head_data)));

    p_irq_from_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(push));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != mode_q) |=> (empty && !full && $stable(rx_irq)));

    p_status_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !pop) |=> (rx_status == '0));
endmodule

bind uart_rx_queue uart_rx_queue_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .mode_q     (mode_q),
    .push       (push),
    .pop        (pop),
    .status_clr (status_clr),
    .depth      (depth),
    .full       (full),
    .empty      (empty),
    .free_slots (free_slots),
    .head_data  (head_data),
    .rx_irq     (rx_irq),
    .rx_status  (rx_status)
);

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic [4:0]  trig_lvl = 5'd1;
    logic        push = 1'b0;
    logic [11:0] push_data = '0;
    logic        pop = 1'b0;
    logic        status_clr = 1'b0;
    logic [11:0] head_data;
    logic [4:0]  free_slots;
    logic        full, empty, rx_irq;
    logic [3:0]  rx_status;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // reference model state
    logic [11:0] m_mem [16];
    int          m_cnt, m_rp;
    bit          m_mode, m_full, m_empty, m_irq;
    logic [3:0]  m_status;

    always #10 clk = ~clk;

    uart_rx_queue uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_lvl(trig_lvl),
        .push(push), .push_data(push_data), .pop(pop), .status_clr(status_clr),
        .head_data(head_data), .free_slots(free_slots), .full(full),
        .empty(empty), .rx_irq(rx_irq), .rx_status(rx_status)
    );

    function automatic int depth_of(bit mode);
        return mode ? 16 : 1;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        m_cnt = 0; m_rp = 0; m_mode = 0;
        m_full = 0; m_empty = 1; m_irq = 0; m_status = '0;
    endtask

    task automatic model_step(bit p, logic [11:0] d, bit q, bit clr, bit mode_i, int trig);
        int dep;
        dep = depth_of(m_mode);
        if (clr) m_status = '0;
        if (mode_i != m_mode) begin
            m_mode = mode_i; m_cnt = 0; m_rp = 0; m_full = 0; m_empty = 1;
        end else begin
            if (q) begin
                m_status = m_mem[m_rp][11:8];
                m_full = 0;
                if (m_cnt > 0) begin
                    m_cnt--;
                    m_rp = (m_rp + 1) % dep;
                end
                if (m_cnt == 0) m_empty = 1;
                if (m_cnt + 1 == trig) m_irq = 0;
            end
            if (p && m_cnt < dep) begin
                m_mem[(m_rp + m_cnt) % dep] = d;
                m_cnt++;
                m_empty = 0;
                if (m_cnt == dep) m_full = 1;
                if (m_cnt == trig) m_irq = 1;
            end
        end
    endtask

    task automatic compare_all(string req);
        check(req, "head_data",  int'(head_data),  int'(m_mem[m_rp]));
        check(req, "free_slots", int'(free_slots), depth_of(m_mode) - m_cnt);
        check(req, "full",       int'(full),       int'(m_full));
        check(req, "empty",      int'(empty),      int'(m_empty));
        check(req, "rx_irq",     int'(rx_irq),     int'(m_irq));
        check(req, "rx_status",  int'(rx_status),  int'(m_status));
    endtask

    task automatic step(string req, bit p, logic [11:0] d, bit q, bit clr, bit mode_i, int trig);
        @(negedge clk);
        push = p; push_data = d; pop = q; status_clr = clr;
        fifo_en = mode_i; trig_lvl = 5'(trig);
        @(posedge clk);
        model_step(p, d, q, clr, mode_i, trig);
        #1;
        compare_all(req);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        check("R1", "free_slots reset", int'(free_slots), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // single-slot mode, trigger 1
        step("R1", 0, 12'h000, 0, 0, 0, 1);
        step("R7", 1, 12'h5A1, 0, 0, 0, 1);
        check("R5", "full single slot", int'(full), 1);
        step("R3", 1, 12'h0B2, 0, 0, 0, 1);
        check("R3", "head kept", int'(head_data), 12'h5A1);
        step("R8", 0, 12'h000, 1, 0, 0, 1);
        check("R11", "status bits", int'(rx_status), 4'h5);
        step("R10", 0, 12'h000, 1, 0, 0, 1);
        check("R10", "stale head", int'(head_data), 12'h5A1);
        step("R11", 0, 12'h000, 0, 1, 0, 1);
        check("R11", "status cleared", int'(rx_status), 0);
        step("R11", 1, 12'hC33, 0, 0, 0, 1);
        step("R11", 0, 12'h000, 1, 1, 0, 1);
        check("R11", "pop wins over clear", int'(rx_status), 4'hC);

        // switch to queue mode with a push on the same cycle
        step("R9", 1, 12'h111, 0, 0, 1, 4);
        check("R9", "free after flush", int'(free_slots), 16);
        for (int i = 0; i < 5; i++) step("R7", 1, 12'(12'h040 + i), 0, 0, 1, 4);
        check("R7", "irq at trigger", int'(rx_irq), 1);
        step("R8", 0, 12'h000, 1, 0, 1, 4);
        step("R8", 0, 12'h000, 1, 0, 1, 4);
        check("R8", "irq cleared", int'(rx_irq), 0);
        for (int i = 0; i < 18; i++) step("R5", 1, 12'(12'h300 + i), 0, 0, 1, 4);
        check("R5", "full 16", int'(full), 1);
        step("R12", 1, 12'hFEE, 1, 0, 1, 4);
        check("R12", "still full", int'(full), 1);
        for (int i = 0; i < 20; i++) step("R4", 0, 12'h000, 1, 0, 1, 4);
        check("R6", "drained", int'(empty), 1);

        // flush while the request is pending
        for (int i = 0; i < 6; i++) step("R7", 1, 12'(12'h700 + i), 0, 0, 1, 2);
        step("R9", 1, 12'h999, 1, 0, 0, 2);
        check("R9", "irq held across flush", int'(rx_irq), 1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit p, q, c, md;
            int tr, sel;
            p  = ($urandom % 10) < 6;
            q  = ($urandom % 10) < 4;
            c  = ($urandom % 20) == 0;
            md = (($urandom % 64) == 0) ? !fifo_en : fifo_en;
            sel = $urandom % 5;
            tr = (sel == 0) ? 1 : (sel == 1) ? 2 : (sel == 2) ? 8 : (sel == 3) ? 16 : 1;
            step("R2", p, 12'($urandom), q, c, md, tr);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule